// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block stands in front of a page buffer controller and filters the stream of write requests so that stray writes cannot alter a non-volatile array. A host turns protection on by issuing a short unlock key: three writes, each with a fixed data byte at a fixed address. The new setting takes effect once the programming cycle that follows the key has ended. While protection is on, a byte or page load reaches the page buffer only if that same key comes directly before it. A longer six-write key, whose first two writes are shared with the unlock key, turns protection off again. Key writes are never passed on to the array.

A write that arrives while protection is on and no key has been given is dropped, but the block asks for a dummy programming cycle, so the host sees the usual busy period. Every key must follow page-load timing: a load-timeout pulse from the external byte-load timer aborts a partial key and closes an open load window. The protection flag survives the block's soft reset and is cleared only by the power-on reset.

The main state machine has the states IDLE (no key or load in progress), KEY1 and KEY2 (first and second key writes seen), DIS3, DIS4 and DIS5 (third to fifth writes of the disable key seen), OPEN (key complete, load window open) and BLOCK (an unkeyed load is being discarded). Transitions: IDLE to KEY1 on the first key write; KEY1 to KEY2 on the second; KEY2 to OPEN on the third enable write (enable key done) or KEY2 to DIS3 on the third disable write; DIS3 to DIS4 to DIS5 on the next disable writes; DIS5 to OPEN on the sixth (disable key done); any key state back to the idle handling on a wrong write (restart); IDLE or a key state to BLOCK on an unkeyed write while protected; any state to IDLE on load timeout; OPEN and BLOCK stay put on writes.

Top module: `wprot_sequencer`

## Requirements
- R1: After power-on reset prot_on is 0 and fwd_valid and dummy_req are 0.
- R2: While protection is off, a write that is not a key write appears on fwd_valid, fwd_addr and fwd_data in the cycle after the request, with the same address and data.
- R3: The enable key is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555; none of these writes is forwarded, and prot_on rises only after the next cycle_done pulse.
- R4: While protected, writes that directly follow a complete key, before load_timeout, are forwarded unchanged one cycle later.
- R5: While protected, an unkeyed write is not forwarded and raises dummy_req for exactly one cycle; later writes of the same load, until load_timeout, are dropped with no further dummy_req.
- R6: A wrong address or data at any key step returns the matcher to idle and the offending write is handled as a fresh write (forwarded when unprotected, dummy cycle when protected).
- R7: A load_timeout pulse during a partial key aborts it, so a following second-step write is treated as an ordinary write.
- R8: A completed key followed by load_timeout without any data write raises dummy_req for one cycle.
- R9: The disable key is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555; prot_on falls only after the next cycle_done pulse.
- R10: prot_on changes only on cycle_done; a soft reset (rst_n low) leaves it unchanged, and only por_n clears it.
- R11: load_timeout closes an open load window, so a later write while protected is blocked.
- R12: Forwarding and dummy requests are registered: they appear exactly one cycle after the triggering request or timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including protection |
| rst_n | input | 1 | Soft reset, active low, clears the sequencer but keeps protection |
| wr_req | input | 1 | Write request strobe, one cycle per write |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| load_timeout | input | 1 | Pulse: byte-load gap exceeded |
| cycle_done | input | 1 | Pulse: programming cycle finished |
| fwd_valid | output | 1 | Forward a write to the page buffer |
| fwd_addr | output | 15 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| dummy_req | output | 1 | Start a programming cycle that writes no data |
| prot_on | output | 1 | Protection active |

## Verification
The hardest situation to reach is the interplay between a key and the load timer: a key that is cut by a timeout, a wrong step in the middle of a key while protected, and a key that opens a window which then closes with no data. The stimulus builds each of these from directed write sequences and explicit timeout and cycle_done pulses, first reaching the protected state through a full enable key and programming cycle, then probing every exit of the key states. Persistence is checked by applying a soft reset while protected and watching prot_on, then applying a power-on reset.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    localparam int DIS_TAIL = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_KEY1  = 3'd1,
        ST_KEY2  = 3'd2,
        ST_DIS3  = 3'd3,
        ST_DIS4  = 3'd4,
        ST_DIS5  = 3'd5,
        ST_OPEN  = 3'd6,
        ST_BLOCK = 3'd7
    } seq_state_e;
endpackage

// File: rtl/wprot_key_match.sv
module wprot_key_match
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] K1_ADDR = 15'h5555,
    parameter logic [DATA_W-1:0] K1_DATA = 8'hAA,
    parameter logic [ADDR_W-1:0] K2_ADDR = 15'h2AAA,
    parameter logic [DATA_W-1:0] K2_DATA = 8'h55,
    parameter logic [ADDR_W-1:0] EN_ADDR = 15'h5555,
    parameter logic [DATA_W-1:0] EN_DATA = 8'hA0,
    parameter logic [DIS_TAIL-1:0][ADDR_W-1:0] DIS_ADDR = {15'h5555, 15'h2AAA, 15'h5555, 15'h5555},
    parameter logic [DIS_TAIL-1:0][DATA_W-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA, 8'h80}
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output logic                hit_k1,
    output logic                hit_k2,
    output logic                hit_en,
    output logic [DIS_TAIL-1:0] hit_dis
);
    assign hit_k1 = (addr == K1_ADDR) && (data == K1_DATA);
    assign hit_k2 = (addr == K2_ADDR) && (data == K2_DATA);
    assign hit_en = (addr == EN_ADDR) && (data == EN_DATA);

    for (genvar i = 0; i < DIS_TAIL; i++) begin : g_dis
        assign hit_dis[i] = (addr == DIS_ADDR[i]) && (data == DIS_DATA[i]);
    end
endmodule

// File: rtl/wprot_seq_fsm.sv
module wprot_seq_fsm
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_req,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                load_timeout,
    input  logic                prot_on,
    input  logic                hit_k1,
    input  logic                hit_k2,
    input  logic                hit_en,
    input  logic [DIS_TAIL-1:0] hit_dis,
    output logic                fwd_valid,
    output logic [ADDR_W-1:0]   fwd_addr,
    output logic [DATA_W-1:0]   fwd_data,
    output logic                dummy_req,
    output logic                en_key,
    output logic                dis_key
);
    seq_state_e state, state_nxt, base;
    logic had_data, had_data_nxt;
    logic do_fwd, do_dummy, do_en, do_dis, restart;

    always_comb begin
        base         = load_timeout ? ST_IDLE : state;
        state_nxt    = base;
        had_data_nxt = had_data;
        do_fwd       = 1'b0;
        do_dummy     = load_timeout && (state == ST_OPEN) && !had_data;
        do_en        = 1'b0;
        do_dis       = 1'b0;
        restart      = 1'b0;
        if (wr_req) begin
            unique case (base)
                ST_IDLE:  restart = 1'b1;
                ST_KEY1:  if (hit_k2) state_nxt = ST_KEY2; else restart = 1'b1;
                ST_KEY2: begin
                    if (hit_en) begin
                        state_nxt    = ST_OPEN;
                        had_data_nxt = 1'b0;
                        do_en        = 1'b1;
                    end else if (hit_dis[0]) begin
                        state_nxt = ST_DIS3;
                    end else begin
                        restart = 1'b1;
                    end
                end
                ST_DIS3:  if (hit_dis[1]) state_nxt = ST_DIS4; else restart = 1'b1;
                ST_DIS4:  if (hit_dis[2]) state_nxt = ST_DIS5; else restart = 1'b1;
                ST_DIS5: begin
                    if (hit_dis[3]) begin
                        state_nxt    = ST_OPEN;
                        had_data_nxt = 1'b0;
                        do_dis       = 1'b1;
                    end else begin
                        restart = 1'b1;
                    end
                end
                ST_OPEN: begin
                    do_fwd       = 1'b1;
                    had_data_nxt = 1'b1;
                end
                ST_BLOCK: state_nxt = ST_BLOCK;
            endcase
            if (restart) begin
                if (hit_k1) begin
                    state_nxt = ST_KEY1;
                end else if (prot_on) begin
                    state_nxt = ST_BLOCK;
                    do_dummy  = 1'b1;
                end else begin
                    state_nxt = ST_IDLE;
                    do_fwd    = 1'b1;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            had_data <= 1'b0;
        end else begin
            state    <= state_nxt;
            had_data <= had_data_nxt;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_addr  <= '0;
            fwd_data  <= '0;
            dummy_req <= 1'b0;
            en_key    <= 1'b0;
            dis_key   <= 1'b0;
        end else begin
            fwd_valid <= do_fwd;
            dummy_req <= do_dummy;
            en_key    <= do_en;
            dis_key   <= do_dis;
            if (do_fwd) begin
                fwd_addr <= wr_addr;
                fwd_data <= wr_data;
            end
        end
    end

    // R5: a load being discarded never reaches the page buffer
    p_block_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCK && wr_req && !load_timeout) |=> !fwd_valid);

    // R3: the first key write is swallowed
    p_key_swallow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_req && !load_timeout && hit_k1) |=> (!fwd_valid && !dummy_req));

    // R4: an open window forwards the write unchanged
    p_open_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && wr_req && !load_timeout)
        |=> (fwd_valid && fwd_addr == $past(wr_addr) && fwd_data == $past(wr_data)));

    // R2: no dummy cycle while unprotected and idle
    p_unprot_no_dummy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !prot_on && wr_req && !load_timeout) |=> !dummy_req);
endmodule

// File: rtl/wprot_prot_state.sv
module wprot_prot_state #(
    parameter logic PROT_AT_POR = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic en_key,
    input  logic dis_key,
    input  logic cycle_done,
    output logic prot_on
);
    logic en_pend, dis_pend;

    // Pending request, cleared by soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_pend  <= 1'b0;
            dis_pend <= 1'b0;
        end else if (en_key) begin
            en_pend  <= 1'b1;
            dis_pend <= 1'b0;
        end else if (dis_key) begin
            en_pend  <= 1'b0;
            dis_pend <= 1'b1;
        end else if (cycle_done) begin
            en_pend  <= 1'b0;
            dis_pend <= 1'b0;
        end
    end

    // Protection flag, cleared only by power-on reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prot_on <= PROT_AT_POR;
        end else if (cycle_done) begin
            if (en_pend)       prot_on <= 1'b1;
            else if (dis_pend) prot_on <= 1'b0;
        end
    end

    // R10: the flag moves only at the end of a programming cycle
    p_prot_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        !cycle_done |=> $stable(prot_on));

    // R3: an enable key alone never turns protection off
    p_en_no_clear_r3: assert property (@(posedge clk) disable iff (!por_n)
        (en_key && prot_on) |=> prot_on);
endmodule

// File: rtl/wprot_sequencer.sv
module wprot_sequencer
    import wprot_pkg::*;
#(
    parameter int   ADDR_W      = 15,
    parameter int   DATA_W      = 8,
    parameter logic PROT_AT_POR = 1'b0,
    parameter logic [DIS_TAIL-1:0][ADDR_W-1:0] DIS_ADDR = {15'h5555, 15'h2AAA, 15'h5555, 15'h5555},
    parameter logic [DIS_TAIL-1:0][DATA_W-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA, 8'h80}
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_timeout,
    input  logic              cycle_done,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic              dummy_req,
    output logic              prot_on
);
    logic                sys_rst_n;
    logic                hit_k1, hit_k2, hit_en;
    logic [DIS_TAIL-1:0] hit_dis;
    logic                en_key, dis_key;

    assign sys_rst_n = rst_n & por_n;

    wprot_key_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .DIS_ADDR(DIS_ADDR), .DIS_DATA(DIS_DATA)
    ) u_match (
        .addr(wr_addr), .data(wr_data),
        .hit_k1(hit_k1), .hit_k2(hit_k2), .hit_en(hit_en), .hit_dis(hit_dis)
    );

    wprot_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(sys_rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_timeout(load_timeout), .prot_on(prot_on),
        .hit_k1(hit_k1), .hit_k2(hit_k2), .hit_en(hit_en), .hit_dis(hit_dis),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
        .dummy_req(dummy_req), .en_key(en_key), .dis_key(dis_key)
    );

    wprot_prot_state #(.PROT_AT_POR(PROT_AT_POR)) u_prot (
        .clk(clk), .por_n(por_n), .rst_n(sys_rst_n),
        .en_key(en_key), .dis_key(dis_key), .cycle_done(cycle_done),
        .prot_on(prot_on)
    );
endmodule

// File: tb/wprot_sequencer_test.sv
`timescale 1ns/1ps
module wprot_sequencer_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        wr_req = 1'b0, load_timeout = 1'b0, cycle_done = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        fwd_valid, dummy_req, prot_on;
    logic [14:0] fwd_addr;
    logic [7:0]  fwd_data;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    wprot_sequencer uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_timeout(load_timeout),
        .cycle_done(cycle_done), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .fwd_data(fwd_data), .dummy_req(dummy_req), .prot_on(prot_on)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic tmo();
        @(negedge clk); load_timeout = 1'b1;
        @(negedge clk); load_timeout = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); cycle_done = 1'b1;
        @(negedge clk); cycle_done = 1'b0;
    endtask

    task automatic enable_key(input string req);
        wr(15'h5555, 8'hAA); chk(req, "key1 fwd", fwd_valid, 0);
        wr(15'h2AAA, 8'h55); chk(req, "key2 fwd", fwd_valid, 0);
        wr(15'h5555, 8'hA0); chk(req, "key3 fwd", fwd_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1", "prot_on", prot_on, 0);
        chk("R1", "fwd_valid", fwd_valid, 0);
        chk("R1", "dummy_req", dummy_req, 0);
    endtask

    task automatic t_unprot();
        wr(15'h1234, 8'h5A);
        chk("R2", "fwd_valid", fwd_valid, 1);
        chk("R2", "fwd_addr", fwd_addr, 15'h1234);
        chk("R12", "fwd_data", fwd_data, 8'h5A);
        @(negedge clk);
        chk("R12", "fwd pulse width", fwd_valid, 0);
        wr(15'h5555, 8'hAA); chk("R3", "lone key1 fwd", fwd_valid, 0);
        wr(15'h0100, 8'h11);
        chk("R6", "mismatch fwd unprot", fwd_valid, 1);
        chk("R6", "mismatch addr", fwd_addr, 15'h0100);
    endtask

    task automatic t_enable();
        enable_key("R3");
        tmo();
        chk("R8", "dummy after empty key", dummy_req, 1);
        chk("R3", "prot before done", prot_on, 0);
        @(negedge clk);
        chk("R8", "dummy pulse width", dummy_req, 0);
        done_pulse();
        chk("R3", "prot after done", prot_on, 1);
    endtask

    task automatic t_blocked();
        wr(15'h0042, 8'h77);
        chk("R5", "blocked fwd", fwd_valid, 0);
        chk("R5", "blocked dummy", dummy_req, 1);
        wr(15'h0043, 8'h78);
        chk("R5", "second fwd", fwd_valid, 0);
        chk("R5", "second dummy", dummy_req, 0);
        tmo();
    endtask

    task automatic t_keyed_load();
        enable_key("R4");
        wr(15'h0200, 8'hC3);
        chk("R4", "load fwd", fwd_valid, 1);
        chk("R4", "load addr", fwd_addr, 15'h0200);
        chk("R4", "load data", fwd_data, 8'hC3);
        wr(15'h0201, 8'h3C);
        chk("R4", "load2 data", fwd_data, 8'h3C);
        tmo();
        chk("R8", "no dummy with data", dummy_req, 0);
        wr(15'h0202, 8'h99);
        chk("R11", "after close fwd", fwd_valid, 0);
        chk("R11", "after close dummy", dummy_req, 1);
        tmo();
    endtask

    task automatic t_mismatch();
        wr(15'h5555, 8'hAA);
        wr(15'h2AAB, 8'h55);
        chk("R6", "bad step fwd", fwd_valid, 0);
        chk("R6", "bad step dummy", dummy_req, 1);
        tmo();
    endtask

    task automatic t_abort();
        wr(15'h5555, 8'hAA);
        tmo();
        wr(15'h2AAA, 8'h55);
        chk("R7", "aborted key dummy", dummy_req, 1);
        chk("R7", "aborted key fwd", fwd_valid, 0);
        tmo();
    endtask

    task automatic t_soft_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10", "prot after soft reset", prot_on, 1);
    endtask

    task automatic t_disable();
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
        chk("R9", "key fwd", fwd_valid, 0);
        tmo();
        chk("R9", "prot before done", prot_on, 1);
        done_pulse();
        chk("R9", "prot after done", prot_on, 0);
        wr(15'h0300, 8'h01);
        chk("R9", "unprot write fwd", fwd_valid, 1);
    endtask

    task automatic t_por();
        enable_key("R10");
        tmo();
        done_pulse();
        chk("R10", "prot set again", prot_on, 1);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        chk("R10", "prot after por", prot_on, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unprot();
        t_enable();
        t_blocked();
        t_keyed_load();
        t_mismatch();
        t_abort();
        t_soft_reset();
        t_disable();
        t_por();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule